// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received frame is kept, based only on its 48-bit destination address. The address is compared against a bank of sixteen exact-match entries. Multicast addresses are also looked up in a 4096-bit hash bit-vector. Broadcast frames pass through a separate enable. Byte 0 of the address sits in bits [7:0] of the address bus, and bit 0 of byte 0 is the multicast flag.

Software fills the filter through a simple register write port. Entry 0 holds the station's own address. Entries 1 to 15 hold the first multicast addresses. Any further multicast addresses are covered only by bits in the hash vector. A combinational flag reports whether the address in entry 0 is a legal individual address.

Lookups use a valid/ready handshake on both sides. An address is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The decision is registered. Once `out_valid` rises, it stays high with a stable decision until `out_ready` is seen high.

Top module: `rx_dest_filter`

## Requirements
- R1: The entry bank has 16 entries, each a pair of 32-bit words. In the low word, address byte 0 is at [7:0] up to byte 3 at [31:24]. In the high word, byte 4 is at [7:0], byte 5 is at [15:0]'s upper half [15:8], and bit 31 is the entry-valid flag. A non-broadcast destination equal to a valid entry gets reason 2'b01 (exact) and `out_accept`=1.
- R2: An entry whose valid flag (high word bit 31) is clear never matches.
- R3: The 12-bit hash window depends on `mode`. Mode 0 takes address bits [47:36], mode 1 takes [46:35], mode 2 takes [45:34] and mode 3 takes [43:32]. Hash bits [11:5] pick the vector word and bits [4:0] pick the bit. A multicast destination with no exact match whose selected bit is set gets reason 2'b10 (hash). If the bit is clear, it gets reason 2'b00 (reject).
- R4: A unicast destination (bit 0 clear) is never accepted through the hash vector.
- R5: The all-ones destination gets reason 2'b11 (broadcast) when the broadcast enable is set, and 2'b00 otherwise, whatever the entries and vector hold.
- R6: The decision for an address taken on a clock edge appears on `out_valid`/`out_reason`/`out_accept` right after that edge. `out_accept` is 1 exactly when the reason is not 2'b00.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the output holds its decision. `in_ready`=1 whenever the output is empty or being drained.
- R8: Configuration map (`cfg_addr[8:7]`):
  - 2'b00 writes entry `cfg_addr[4:1]`, with `cfg_addr[0]` selecting the high word (1) or the low word (0).
  - 2'b01 writes vector word `cfg_addr[6:0]`.
  - 2'b10 writes control: `cfg_wdata[1:0]` is the hash mode and `cfg_wdata[2]` is the broadcast enable.

  A write sampled on the same edge as a lookup does not affect that lookup. It does affect the next one.
- R9: After reset, `out_valid`=0, `in_ready`=1, and all entries, vector words, mode and broadcast enable are zero, so every lookup is rejected.
- R10: `stn_addr_ok` is 1 exactly when the address bits of entry 0 are neither multicast (bit 0 set), nor all ones, nor all zeros.
- R11: A multicast destination that both exactly matches an entry and has its hash bit set reports exact (2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 9 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Destination address valid |
| in_ready | output | 1 | Filter can take an address |
| in_addr | input | 48 | Destination address, byte 0 in [7:0] |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Consumer takes the decision |
| out_accept | output | 1 | Frame is accepted |
| out_reason | output | 2 | 00 reject, 01 exact, 10 hash, 11 broadcast |
| stn_addr_ok | output | 1 | Entry 0 holds a legal individual address |

## Verification
All fifteen multicast entries are written with distinct addresses and looked up. One entry's valid flag is then cleared, which separates a real compare from one that ignores the flag.

For every hash mode, twelve computed addresses are tried in three ways. Each is tried with its own hash bit set, with only the neighbouring bit set, and with the multicast bit cleared. This exposes a wrong window offset, a wrong word/bit split, and hash acceptance of unicast.

Broadcast is tried with the enable both off and on. Same-edge configuration writes, a stalled output with a second address waiting, and the four station-address classes (good, multicast, all ones, zero) round out the cases.

// File: rtl/rxdaf_pkg.sv
package rxdaf_pkg;
  typedef enum logic [1:0] {
    RSN_REJECT = 2'b00,
    RSN_EXACT  = 2'b01,
    RSN_HASH   = 2'b10,
    RSN_BCAST  = 2'b11
  } reason_e;

  localparam int DA_W = 48;

  localparam logic [1:0] REG_ENTRY = 2'b00;
  localparam logic [1:0] REG_HASH  = 2'b01;
  localparam logic [1:0] REG_CTRL  = 2'b10;
endpackage

// File: rtl/rxdaf_exact_bank.sv
module rxdaf_exact_bank #(
  parameter int N_ENTRIES = 16,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 48,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int HI_W     = ADDR_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] stn_addr
);
  // high part keeps only the address bits plus the valid flag
  logic [WORD_W-1:0] lo_q [N_ENTRIES];
  logic [HI_W:0]     hi_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENTRIES; e++) begin
        lo_q[e] <= '0;
        hi_q[e] <= '0;
      end
    end else if (wr_en) begin
      if (wr_hi) hi_q[wr_idx] <= {wr_data[WORD_W-1], wr_data[HI_W-1:0]};
      else       lo_q[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    assign match[g] = hi_q[g][HI_W] &&
                      (hi_q[g][HI_W-1:0] == lookup_addr[ADDR_W-1:WORD_W]) &&
                      (lo_q[g] == lookup_addr[WORD_W-1:0]);
  end

  assign hit      = |match;
  assign stn_addr = {hi_q[0][HI_W-1:0], lo_q[0]};

  AST_ENTRY_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> hi_q[$past(wr_idx)] == {$past(wr_data[WORD_W-1]), $past(wr_data[HI_W-1:0])}); // R8
endmodule

// File: rtl/rxdaf_hash_table.sv
module rxdaf_hash_table #(
  parameter int HASH_WORDS = 128,
  parameter int WORD_W     = 32,
  localparam int WIDX_W    = $clog2(HASH_WORDS),
  localparam int BIT_W     = $clog2(WORD_W),
  localparam int HASH_W    = WIDX_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        mode,
  input  logic [15:0]       addr_top,   // address bytes 5 and 4
  output logic              bit_set
);
  logic [WORD_W-1:0] vec_q [HASH_WORDS];
  logic [HASH_W-1:0] hash;
  logic [WORD_W-1:0] sel_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < HASH_WORDS; w++) vec_q[w] <= '0;
    end else if (wr_en) begin
      vec_q[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    unique case (mode)
      2'd0:    hash = addr_top[15 -: HASH_W];
      2'd1:    hash = addr_top[14 -: HASH_W];
      2'd2:    hash = addr_top[13 -: HASH_W];
      default: hash = addr_top[HASH_W-1:0];
    endcase
  end

  assign sel_word = vec_q[hash[HASH_W-1:BIT_W]];
  assign bit_set  = sel_word[hash[BIT_W-1:0]];

  AST_VEC_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vec_q[$past(wr_idx)] == $past(wr_data)); // R8
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxdaf_pkg::*;
#(
  parameter int N_ENTRIES  = 16,
  parameter int HASH_WORDS = 128,
  parameter int WORD_W     = 32,
  localparam int IDX_W     = $clog2(N_ENTRIES),
  localparam int WIDX_W    = $clog2(HASH_WORDS),
  localparam int CFG_AW    = 2 + ((WIDX_W > IDX_W + 1) ? WIDX_W : IDX_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DA_W-1:0]   in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_accept,
  output logic [1:0]        out_reason,
  output logic              stn_addr_ok
);
  logic [1:0]      region;
  logic            ent_we, vec_we, ctl_we;
  logic [1:0]      mode_q;
  logic            bcast_en_q;
  logic            exact_hit, hash_hit;
  logic [DA_W-1:0] stn_addr;
  reason_e         rsn_d, rsn_q;
  logic            fire;

  assign region = cfg_addr[CFG_AW-1 -: 2];
  assign ent_we = cfg_we && (region == REG_ENTRY);
  assign vec_we = cfg_we && (region == REG_HASH);
  assign ctl_we = cfg_we && (region == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      bcast_en_q <= 1'b0;
    end else if (ctl_we) begin
      mode_q     <= cfg_wdata[1:0];
      bcast_en_q <= cfg_wdata[2];
    end
  end

  rxdaf_exact_bank #(
    .N_ENTRIES(N_ENTRIES), .WORD_W(WORD_W), .ADDR_W(DA_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ent_we), .wr_idx(cfg_addr[IDX_W:1]), .wr_hi(cfg_addr[0]),
    .wr_data(cfg_wdata), .lookup_addr(in_addr),
    .hit(exact_hit), .stn_addr(stn_addr)
  );

  rxdaf_hash_table #(
    .HASH_WORDS(HASH_WORDS), .WORD_W(WORD_W)
  ) u_vec (
    .clk(clk), .rst_n(rst_n),
    .wr_en(vec_we), .wr_idx(cfg_addr[WIDX_W-1:0]), .wr_data(cfg_wdata),
    .mode(mode_q), .addr_top(in_addr[DA_W-1 -: 16]),
    .bit_set(hash_hit)
  );

  // broadcast first, then exact, then hash (multicast only)
  always_comb begin
    if (&in_addr)                       rsn_d = bcast_en_q ? RSN_BCAST : RSN_REJECT;
    else if (exact_hit)                 rsn_d = RSN_EXACT;
    else if (in_addr[0] && hash_hit)    rsn_d = RSN_HASH;
    else                                rsn_d = RSN_REJECT;
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rsn_q     <= RSN_REJECT;
    end else if (fire) begin
      out_valid <= 1'b1;
      rsn_q     <= rsn_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_reason  = rsn_q;
  assign out_accept  = (rsn_q != RSN_REJECT);
  assign stn_addr_ok = !stn_addr[0] && !(&stn_addr) && (|stn_addr);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_reason))); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R6
  AST_UNICAST_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_addr[0]) |=> (out_reason != RSN_HASH)); // R4
  AST_BCAST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (&in_addr) && !bcast_en_q) |=> (out_reason == RSN_REJECT)); // R5
endmodule

// File: tb/tb_rx_dest_filter.sv
`timescale 1ns/1ps
module tb_rx_dest_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_accept;
  logic [1:0]  out_reason;
  logic        stn_addr_ok;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] REJ = 2'b00, EXA = 2'b01, HSH = 2'b10, BCA = 2'b11;

  always #5 clk = ~clk;

  rx_dest_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_accept(out_accept), .out_reason(out_reason), .stn_addr_ok(stn_addr_ok)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_entry(input int idx, input logic [47:0] a, input bit vld);
    wr({2'b00, 2'b00, 4'(idx), 1'b0}, a[31:0]);
    wr({2'b00, 2'b00, 4'(idx), 1'b1}, {vld, 15'd0, a[47:32]});
  endtask

  task automatic look(input logic [47:0] a, input logic [1:0] exp, input string req);
    @(negedge clk);
    in_addr = a; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, req, {63'd0, out_valid}, 64'd1);
    chk(out_reason == exp && out_accept == (exp != REJ), req,
        {61'd0, out_accept, out_reason}, {61'd0, (exp != REJ), exp});
  endtask

  function automatic logic [11:0] hash_of(input logic [47:0] a, input int m);
    int sh;
    sh = (m == 0) ? 4 : (m == 1) ? 3 : (m == 2) ? 2 : 0;
    return 12'((a[47:32] >> sh) & 16'h0fff);
  endfunction

  function automatic logic [47:0] ent_addr(input int i);
    return {8'(8'h40 + i), 8'(8'h11 * i), 8'h22, 8'h33, 8'(i), 8'(i * 2 + (i % 2))};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [11:0] h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9 out_valid", {63'd0, out_valid}, 0);
    chk(in_ready == 1'b1, "R9 in_ready", {63'd0, in_ready}, 1);
    chk(stn_addr_ok == 1'b0, "R9 R10 stn zero", {63'd0, stn_addr_ok}, 0);
    look(48'hffff_ffff_ffff, REJ, "R9 R5 bcast off");
    look(48'h0102_0304_0501, REJ, "R9 empty filter");

    // R5 broadcast enable
    wr(9'h100, 32'h4);
    look(48'hffff_ffff_ffff, BCA, "R5 bcast on");

    // R1 exact entries 1..15
    for (int i = 1; i < 16; i++) wr_entry(i, ent_addr(i), 1'b1);
    for (int i = 1; i < 16; i++) look(ent_addr(i), EXA, "R1 exact");
    look(ent_addr(4) ^ 48'h0100, REJ, "R1 near miss");

    // R2 valid flag clear
    wr_entry(5, ent_addr(5), 1'b0);
    look(ent_addr(5), REJ, "R2 invalid entry");
    look(ent_addr(6), EXA, "R2 neighbour intact");

    // R11 exact wins over hash (entry 3 address is multicast)
    h = hash_of(ent_addr(3), 0);
    wr({2'b01, h[11:5]}, 32'(1) << h[4:0]);
    look(ent_addr(3), EXA, "R11 exact priority");
    wr({2'b01, h[11:5]}, 32'h0);

    // R3 / R4 hash sweep over every mode
    for (int m = 0; m < 4; m++) begin
      wr(9'h100, 32'(4 + m));
      for (int k = 0; k < 12; k++) begin
        a = {8'(k * 37 + m * 11 + 1), 8'(k * 53 + 7), 32'h0000_0001};
        h = hash_of(a, m);
        wr({2'b01, h[11:5]}, 32'(1) << h[4:0]);
        look(a, HSH, "R3 hash bit set");
        look(a & ~48'h1, REJ, "R4 unicast via hash");
        wr({2'b01, h[11:5]}, 32'(1) << (h[4:0] ^ 5'd1));
        look(a, REJ, "R3 neighbour bit only");
        wr({2'b01, h[11:5]}, 32'h0);
      end
    end

    // R10 station flag
    wr_entry(0, 48'h0a0b_0c0d_0e10, 1'b1);
    @(negedge clk);
    chk(stn_addr_ok == 1'b1, "R10 good", {63'd0, stn_addr_ok}, 1);
    wr_entry(0, 48'h0a0b_0c0d_0e11, 1'b1);
    @(negedge clk);
    chk(stn_addr_ok == 1'b0, "R10 multicast", {63'd0, stn_addr_ok}, 0);
    wr_entry(0, 48'hffff_ffff_ffff, 1'b1);
    @(negedge clk);
    chk(stn_addr_ok == 1'b0, "R10 all ones", {63'd0, stn_addr_ok}, 0);
    wr_entry(0, 48'h0, 1'b1);
    @(negedge clk);
    chk(stn_addr_ok == 1'b0, "R10 zero", {63'd0, stn_addr_ok}, 0);

    // R7 / R6 back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_addr = 48'hffff_ffff_ffff; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid && out_reason == BCA, "R6 first taken", {62'd0, out_reason}, BCA);
    chk(in_ready == 1'b0, "R7 ready low", {63'd0, in_ready}, 0);
    in_addr = ent_addr(7);
    repeat (3) @(negedge clk);
    chk(out_valid && out_reason == BCA, "R7 held", {62'd0, out_reason}, BCA);
    chk(in_ready == 1'b0, "R7 still stalled", {63'd0, in_ready}, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_reason == EXA, "R6 second taken", {62'd0, out_reason}, EXA);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 drained", {63'd0, out_valid}, 0);

    // R8 same-edge write does not affect that lookup
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {2'b00, 2'b00, 4'd2, 1'b1}; cfg_wdata = 32'h0;
    in_addr = ent_addr(2); in_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk(out_reason == EXA, "R8 same edge old", {62'd0, out_reason}, EXA);
    look(ent_addr(2), REJ, "R8 next lookup new");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule